// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

This block is an operating-system timer for a host processor. A single 32-bit counter advances by one on every cycle in which the tick-enable input is high. Four 32-bit compare registers watch that counter. When the counter equals a compare value on a tick, the channel's status bit is set and its interrupt line goes high, but only if that channel's interrupt enable is set. Software clears a status bit, and lowers its interrupt line, by writing a one to that bit.

Channel 3 can also serve as a watchdog. After software arms the watchdog, a channel-3 match produces a one-clock reset request, whether or not channel 3's interrupt is enabled. Once armed, the watchdog cannot be disarmed except by reset. Software reaches all state through a plain single-cycle register port: a write strobe with address and data, and a read path that decodes the address combinationally. The tick-enable input comes from a clock-enable generator outside the block, so the tick rate is set by the system (nominally a few MHz).

Top module: `os_match_timer`

## Requirements
- R1: After reset the counter, all compare registers, the status bits, the interrupt enables and the watchdog arm bit are 0, and `irq` and `rst_req` are low.
- R2: The counter increments by one on each clock with `tick_en` high, holds otherwise, and wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x10 loads the counter with `wdata`, and a load takes priority over a tick in the same cycle. Counting then continues from the loaded value.
- R4: On a clock with `tick_en` high, compare register n (offset 4*n, n = 0..3) is compared for exact equality with the counter value before the edge. On equality with enable bit n set, status bit n and `irq[n]` are high from the next cycle.
- R5: A match on channel n while enable bit n is clear leaves status bit n and `irq[n]` low.
- R6: A write to offset 0x14 clears each status bit n where `wdata[n]` is 1 and leaves the others. If a new match sets a bit in the same cycle that clears it, the set wins.
- R7: Offset 0x1C holds the interrupt enables. Only `wdata[11:0]` are kept, upper read bits are 0, and bits 3..0 gate channels 3..0.
- R8: Writing 1 to bit 0 at offset 0x18 arms the watchdog. Writing 0 does not disarm it; only reset does. A read returns the arm bit in bit 0.
- R9: A channel-3 match while the watchdog is armed (armed before that cycle) drives `rst_req` high for exactly the next clock, regardless of enable bit 3.
- R10: Reads return the addressed register; a read or write at an unmapped offset returns 0 and changes no state, status bit or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance strobe, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | Per-channel interrupt lines (status bits) |
| rst_req | output | 1 | One-clock watchdog reset request |

## Verification
The collision that matters is a match setting a status bit in the same cycle that software writes a one to clear it. The bench provokes this by loading the counter two below the compare value, ticking twice, and writing the clear on the third tick, then expects the bit to stay set. A second collision is a counter load in a tick cycle, where the load must win. Random traffic also places compare values near the counter and mixes clears, loads, enable changes and watchdog arming with ticks. Every output and read value is compared cycle by cycle against a reference model in the bench.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam int unsigned OST_DW    = 32;
  localparam int unsigned OST_AW    = 8;
  localparam int unsigned OST_NCH   = 4;
  localparam int unsigned OST_IEN_W = 12;

  localparam logic [OST_AW-1:0] OFF_COUNT  = 8'h10;
  localparam logic [OST_AW-1:0] OFF_STATUS = 8'h14;
  localparam logic [OST_AW-1:0] OFF_WDOG   = 8'h18;
  localparam logic [OST_AW-1:0] OFF_IEN    = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MATCH, SEL_COUNT, SEL_STATUS, SEL_WDOG, SEL_IEN
  } ost_sel_e;
endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] count
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (tick)  cnt_q <= cnt_q + {{(DW-1){1'b0}}, 1'b1};
  end

  assign count = cnt_q;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load |=> $stable(cnt_q));
  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/ost_match_chan.sv
module ost_match_chan #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] count,
  input  logic          wr_match,
  input  logic [DW-1:0] wdata,
  input  logic          irq_en,
  input  logic          clr,
  output logic [DW-1:0] match_val,
  output logic          hit,
  output logic          flag
);
  logic [DW-1:0] match_q;
  logic          flag_q;
  logic          set_flag;

  always_ff @(posedge clk) begin
    if (!rst_n)        match_q <= '0;
    else if (wr_match) match_q <= wdata;
  end

  assign hit      = tick && (count == match_q);
  assign set_flag = hit && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (set_flag) flag_q <= 1'b1;
    else if (clr)      flag_q <= 1'b0;
  end

  assign match_val = match_q;
  assign flag      = flag_q;

  a_r4_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count == match_q && irq_en |=> flag_q);
  a_r5_gated_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(irq_en) && $past(tick));
  a_r6_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(hit && irq_en) |=> !flag_q);
endmodule

// File: rtl/ost_decode.sv
module ost_decode
  import ost_pkg::*;
#(
  parameter int unsigned AW  = 8,
  parameter int unsigned NCH = 4,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0] addr,
  output ost_sel_e      sel,
  output logic [IW-1:0] chan
);
  always_comb begin
    sel  = SEL_NONE;
    chan = '0;
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(4 * n)) begin
        sel  = SEL_MATCH;
        chan = IW'(n);
      end
    end
    if (addr == OFF_COUNT)  sel = SEL_COUNT;
    if (addr == OFF_STATUS) sel = SEL_STATUS;
    if (addr == OFF_WDOG)   sel = SEL_WDOG;
    if (addr == OFF_IEN)    sel = SEL_IEN;
  end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import ost_pkg::*;
#(
  parameter int unsigned DW    = OST_DW,
  parameter int unsigned AW    = OST_AW,
  parameter int unsigned NCH   = OST_NCH,
  parameter int unsigned IEN_W = OST_IEN_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq,
  output logic           rst_req
);
  localparam int unsigned IW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned WD_CH = NCH - 1;

  ost_sel_e          sel;
  logic [IW-1:0]     chan;
  logic [DW-1:0]     count;
  logic [IEN_W-1:0]  ien_q;
  logic              wd_arm_q;
  logic              rst_req_q;
  logic [NCH-1:0]    hit;
  logic [NCH-1:0]    flag;
  logic [DW-1:0]     match_val [NCH];
  logic              wr_count, wr_status, wr_wdog, wr_ien;

  ost_decode #(.AW(AW), .NCH(NCH)) u_dec (
    .addr (addr),
    .sel  (sel),
    .chan (chan)
  );

  assign wr_count  = wr_en && (sel == SEL_COUNT);
  assign wr_status = wr_en && (sel == SEL_STATUS);
  assign wr_wdog   = wr_en && (sel == SEL_WDOG);
  assign wr_ien    = wr_en && (sel == SEL_IEN);

  ost_counter #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .load     (wr_count),
    .load_val (wdata),
    .count    (count)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    ost_match_chan #(.DW(DW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_en),
      .count     (count),
      .wr_match  (wr_en && sel == SEL_MATCH && chan == IW'(n)),
      .wdata     (wdata),
      .irq_en    (ien_q[n]),
      .clr       (wr_status && wdata[n]),
      .match_val (match_val[n]),
      .hit       (hit[n]),
      .flag      (flag[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= wdata[IEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   wd_arm_q <= 1'b0;
    else if (wr_wdog && wdata[0]) wd_arm_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= hit[WD_CH] && wd_arm_q;
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_MATCH:  rdata = match_val[chan];
      SEL_COUNT:  rdata = count;
      SEL_STATUS: rdata = DW'(flag);
      SEL_WDOG:   rdata = DW'(wd_arm_q);
      SEL_IEN:    rdata = DW'(ien_q);
      default:    rdata = '0;
    endcase
  end

  assign irq     = flag;
  assign rst_req = rst_req_q;

  a_r8_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wd_arm_q) |-> wd_arm_q);
  a_r9_req_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wd_arm_q) && $past(hit[WD_CH]));
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_NONE |-> rdata == '0);
  a_r7_ien_width: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_IEN |-> rdata[DW-1:IEN_W] == '0);
endmodule

// File: tb/os_match_timer_test.sv
module os_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_cnt;
  logic [31:0] m_match [4];
  logic [3:0]  m_stat;
  logic [11:0] m_ien;
  logic        m_wd;
  logic        m_rst;
  logic [31:0] last_rd;

  always #10 clk = ~clk;

  os_match_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return m_match[0];
      8'h04: return m_match[1];
      8'h08: return m_match[2];
      8'h0C: return m_match[3];
      8'h10: return m_cnt;
      8'h14: return {28'd0, m_stat};
      8'h18: return {31'd0, m_wd};
      8'h1C: return {20'd0, m_ien};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_stat = '0; m_ien = '0; m_wd = 1'b0; m_rst = 1'b0;
    for (int n = 0; n < 4; n++) m_match[n] = '0;
  endtask

  // one clock: drive at negedge, check read before edge, outputs after edge
  task automatic step(input bit t, input bit w, input logic [7:0] a,
                      input logic [31:0] d);
    logic [3:0] h;
    logic [31:0] exp_rd;
    tick_en = t; wr_en = w; addr = a; wdata = d;
    #1;
    exp_rd = model_read(a);
    last_rd = rdata;
    chk(rdata === exp_rd, "R10 read", rdata, exp_rd);
    for (int n = 0; n < 4; n++) h[n] = t && (m_cnt == m_match[n]);
    m_rst = h[3] && m_wd;
    if (w && a == 8'h14) m_stat = m_stat & ~d[3:0];
    m_stat = m_stat | (h & m_ien[3:0]);
    if (w && a == 8'h10) m_cnt = d;
    else if (t) m_cnt = m_cnt + 32'd1;
    if (w && a[7:4] == 4'h0 && a[1:0] == 2'b00) m_match[a[3:2]] = d;
    if (w && a == 8'h1C) m_ien = d[11:0];
    if (w && a == 8'h18 && d[0]) m_wd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    chk(irq === m_stat, "R4 irq vs model", {28'd0, irq}, {28'd0, m_stat});
    chk(rst_req === m_rst, "R9 rst_req vs model", {31'd0, rst_req}, {31'd0, m_rst});
  endtask

  task automatic rd(input logic [7:0] a);
    step(1'b0, 1'b0, a, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] a;
    logic [31:0] d;
    void'($urandom(32'd20250611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(irq === 4'h0, "R1 irq after reset", {28'd0, irq}, 32'd0);
    chk(rst_req === 1'b0, "R1 rst_req after reset", {31'd0, rst_req}, 32'd0);
    rd(8'h10); chk(last_rd === 32'd0, "R1 counter", last_rd, 32'd0);
    rd(8'h0C); chk(last_rd === 32'd0, "R1 match3", last_rd, 32'd0);
    rd(8'h1C); chk(last_rd === 32'd0, "R1 enables", last_rd, 32'd0);

    // R2 wrap and hold
    step(1'b0, 1'b1, 8'h10, 32'hFFFF_FFFF);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    rd(8'h10); chk(last_rd === 32'd0, "R2 wrap", last_rd, 32'd0);
    rd(8'h10); chk(last_rd === 32'd0, "R2 hold without tick", last_rd, 32'd0);

    // R3 load beats tick
    step(1'b1, 1'b1, 8'h10, 32'h0000_1234);
    rd(8'h10); chk(last_rd === 32'h1234, "R3 load wins", last_rd, 32'h1234);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    rd(8'h10); chk(last_rd === 32'h1235, "R3 continues", last_rd, 32'h1235);

    // R7 enable width
    step(1'b0, 1'b1, 8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C); chk(last_rd === 32'h0000_0FFF, "R7 low 12 bits", last_rd, 32'hFFF);

    // R4 enabled match, R5 disabled match
    step(1'b0, 1'b1, 8'h1C, 32'h0000_0001);
    step(1'b0, 1'b1, 8'h00, 32'd102);
    step(1'b0, 1'b1, 8'h04, 32'd102);
    step(1'b0, 1'b1, 8'h10, 32'd100);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    chk(irq === 4'h0, "R4 no early set", {28'd0, irq}, 32'd0);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    chk(irq[0] === 1'b1, "R4 match sets irq0", {31'd0, irq[0]}, 32'd1);
    chk(irq[1] === 1'b0, "R5 disabled channel stays low", {31'd0, irq[1]}, 32'd0);

    // R6 clear, and set winning over clear
    step(1'b0, 1'b1, 8'h14, 32'h0000_0002);
    chk(irq[0] === 1'b1, "R6 zero bit untouched", {31'd0, irq[0]}, 32'd1);
    step(1'b0, 1'b1, 8'h14, 32'h0000_0001);
    chk(irq[0] === 1'b0, "R6 clear", {31'd0, irq[0]}, 32'd0);
    step(1'b0, 1'b1, 8'h10, 32'd100);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    step(1'b1, 1'b1, 8'h14, 32'h0000_0001);
    chk(irq[0] === 1'b1, "R6 set wins over clear", {31'd0, irq[0]}, 32'd1);
    step(1'b0, 1'b1, 8'h14, 32'h0000_000F);

    // R8 and R9 watchdog
    step(1'b0, 1'b1, 8'h1C, 32'h0000_0000);
    step(1'b0, 1'b1, 8'h0C, 32'd201);
    step(1'b0, 1'b1, 8'h10, 32'd200);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    chk(rst_req === 1'b0, "R9 no request unarmed", {31'd0, rst_req}, 32'd0);
    step(1'b0, 1'b1, 8'h18, 32'h0000_0001);
    step(1'b0, 1'b1, 8'h18, 32'h0000_0000);
    rd(8'h18); chk(last_rd === 32'd1, "R8 arm sticky", last_rd, 32'd1);
    step(1'b0, 1'b1, 8'h10, 32'd200);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    chk(rst_req === 1'b1, "R9 request pulse", {31'd0, rst_req}, 32'd1);
    chk(irq[3] === 1'b0, "R9 irq3 stays masked", {31'd0, irq[3]}, 32'd0);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    chk(rst_req === 1'b0, "R9 one clock only", {31'd0, rst_req}, 32'd0);

    // R10 unmapped access
    step(1'b0, 1'b1, 8'h24, 32'hDEAD_BEEF);
    rd(8'h24); chk(last_rd === 32'd0, "R10 unmapped read", last_rd, 32'd0);
    rd(8'h0C); chk(last_rd === 32'd201, "R10 state kept", last_rd, 32'd201);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      a = 8'(4 * $urandom_range(0, 9));
      case (k)
        0, 1: d = m_cnt + 32'($urandom_range(0, 6));
        2:    d = $urandom_range(0, 15);
        3:    d = 32'hFFFF_FFFF - 32'($urandom_range(0, 3));
        default: d = $urandom;
      endcase
      if (a == 8'h10 && $urandom_range(0, 3) != 0) a = 8'h14;
      if (a == 8'h18 && $urandom_range(0, 7) != 0) a = 8'h1C;
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0), a, d);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule